// File: doc/BRIEF.md
# Resonance-Seeking Oscillator Code Calibrator

This block picks the carrier frequency of an on-off-keyed link so that it sits on the resonant point of a long on-sheet interconnect. The carrier comes from a digitally controlled oscillator driven by an 8-bit code. On a start command the block sweeps that code upward from a configurable first code to a configurable last code, inclusive. At each step it lets the oscillator and the receive path settle for a programmable number of cycles, then takes one digitized receive-envelope sample. It keeps the code whose envelope was largest. When the sweep ends it drives that code onto the oscillator and keeps it frozen for normal transmission until the next start.

The resonance may sit well away from the nominal carrier, on either side of it. The sweep limits are inputs so that software can centre the window. While the block is calibrating, transmit enable is forced low. The state machine has four states. ST_IDLE holds the frozen code and waits for a start. ST_SETTLE counts the settle interval. ST_SAMPLE compares one envelope sample against the best so far. ST_LOCK applies the winning code and raises done.

The transitions are as follows:
- ST_IDLE goes to ST_SETTLE on start.
- ST_SETTLE goes to ST_SAMPLE when the settle counter is exhausted.
- ST_SAMPLE goes back to ST_SETTLE when codes remain, or to ST_LOCK after the last code.
- ST_LOCK always returns to ST_IDLE.

Top module: `dco_peak_cal`

## Requirements
- R1: After reset, dco_code_o is 0x80 (the nominal code, parameter RESET_CODE), and busy_o, done_o, peak_o and tx_en_o are all 0.
- R2: A start_i seen in the idle state raises busy_o and clears done_o in the next cycle. In that same cycle dco_code_o equals code_lo_i, and the first and last codes and the settle count are captured.
- R3: Each code is held for settle_i+1 settle cycles plus one sample cycle. A sweep of N codes therefore keeps busy_o high for exactly N*(settle_i+2)+1 cycles, the final cycle being the lock cycle.
- R4: The envelope samples are compared as unsigned numbers. At the end of the sweep, dco_code_o is the swept code with the largest envelope and peak_o is that envelope value.
- R5: If several codes share the largest envelope, the lowest of them is chosen.
- R6: The sweep covers every code from code_lo_i up to code_hi_i inclusive, in ascending order. If code_hi_i is below code_lo_i, only code_lo_i is measured (N = 1).
- R7: After done_o rises, dco_code_o, peak_o and done_o stay unchanged until the next start, whatever the envelope does.
- R8: tx_en_o equals tx_req_i while busy_o is low, and is 0 whenever busy_o is high.
- R9: A start_i received while busy_o is high is ignored. This includes a start in the lock cycle: the running sweep ends normally and no new sweep begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Calibration start request |
| code_lo_i | input | 8 | First oscillator code of the sweep |
| code_hi_i | input | 8 | Last oscillator code of the sweep (inclusive) |
| settle_i | input | 16 | Settle cycles per step, minus one |
| env_i | input | 10 | Digitized receive envelope (unsigned) |
| tx_req_i | input | 1 | Transmit request from the link |
| dco_code_o | output | 8 | Oscillator tuning code |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | A calibration has completed and its code is applied |
| peak_o | output | 10 | Envelope value of the chosen code |
| tx_en_o | output | 1 | Transmit enable, gated off while busy |

## Verification
Two functions can land on the same clock edge: a fresh start request and the lock step, which applies the winning code and raises done. The bench provokes this by raising start in exactly the cycle it computes to be the last busy cycle. It then judges that busy falls and stays low, that done rises, and that the code and peak are those of the interrupted sweep. A start in the middle of a sweep is also injected, and the sweep length and result are checked to be unchanged.

// File: rtl/dcal_pkg.sv
package dcal_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_SAMPLE,
        ST_LOCK
    } cal_state_e;
endpackage

// File: rtl/dcal_settle_timer.sv
// Down-counter that holds each oscillator step for a programmed interval.
module dcal_settle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/dcal_peak_track.sv
// Keeps the best envelope seen in a sweep and the code that produced it.
// Only a strictly larger sample replaces the best one, so on an ascending
// sweep the lowest of several equal codes survives.
module dcal_peak_track #(
    parameter int CODE_W = 8,
    parameter int ENV_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              upd_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [ENV_W-1:0]  env_i,
    output logic [CODE_W-1:0] best_code_o,
    output logic [ENV_W-1:0]  best_env_o
);
    logic              first_q;
    logic [CODE_W-1:0] best_code_q;
    logic [ENV_W-1:0]  best_env_q;
    logic              take;

    assign take = upd_i && (first_q || (env_i > best_env_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q     <= 1'b1;
            best_code_q <= '0;
            best_env_q  <= '0;
        end else if (clr_i) begin
            first_q     <= 1'b1;
            best_code_q <= '0;
            best_env_q  <= '0;
        end else if (take) begin
            first_q     <= 1'b0;
            best_code_q <= code_i;
            best_env_q  <= env_i;
        end
    end

    assign best_code_o = best_code_q;
    assign best_env_o  = best_env_q;
endmodule

// File: rtl/dco_peak_cal.sv
module dco_peak_cal
    import dcal_pkg::*;
#(
    parameter int          CODE_W     = 8,
    parameter int          ENV_W      = 10,
    parameter int          SETTLE_W   = 16,
    parameter logic [7:0]  RESET_CODE = 8'h80
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [CODE_W-1:0]   code_lo_i,
    input  logic [CODE_W-1:0]   code_hi_i,
    input  logic [SETTLE_W-1:0] settle_i,
    input  logic [ENV_W-1:0]    env_i,
    input  logic                tx_req_i,
    output logic [CODE_W-1:0]   dco_code_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [ENV_W-1:0]    peak_o,
    output logic                tx_en_o
);
    localparam logic [CODE_W-1:0] RST_CODE = CODE_W'(RESET_CODE);

    cal_state_e state_q, state_d;

    logic [CODE_W-1:0]   code_q;
    logic [CODE_W-1:0]   end_q;
    logic [SETTLE_W-1:0] settle_q;
    logic                done_q;

    logic                start_go;
    logic                last_code;
    logic                tmr_load;
    logic                tmr_tick;
    logic [SETTLE_W-1:0] tmr_val;
    logic                tmr_expired;
    logic                trk_clr;
    logic                trk_upd;
    logic [CODE_W-1:0]   best_code;
    logic [ENV_W-1:0]    best_env;

    // The sweep ends at the captured last code, or at once if it lies below the first.
    assign last_code = (code_q >= end_q);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_SETTLE;
            ST_SETTLE: if (tmr_expired) state_d = ST_SAMPLE;
            ST_SAMPLE: state_d = last_code ? ST_LOCK : ST_SETTLE;
            ST_LOCK:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs and control strobes
    always_comb begin
        start_go = 1'b0;
        tmr_load = 1'b0;
        tmr_tick = 1'b0;
        tmr_val  = settle_q;
        trk_clr  = 1'b0;
        trk_upd  = 1'b0;
        busy_o   = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy_o   = 1'b0;
                start_go = start_i;
                tmr_load = start_i;
                tmr_val  = settle_i;
                trk_clr  = start_i;
            end
            ST_SETTLE: tmr_tick = 1'b1;
            ST_SAMPLE: begin
                trk_upd  = 1'b1;
                tmr_load = !last_code;
            end
            ST_LOCK: ;
            default: busy_o = 1'b0;
        endcase
        tx_en_o = tx_req_i && !busy_o;
    end

    // Sweep datapath: step code, capture limits, apply the winning code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q   <= RST_CODE;
            end_q    <= '0;
            settle_q <= '0;
            done_q   <= 1'b0;
        end else if (start_go) begin
            code_q   <= code_lo_i;
            end_q    <= code_hi_i;
            settle_q <= settle_i;
            done_q   <= 1'b0;
        end else if (state_q == ST_SAMPLE && !last_code) begin
            code_q   <= code_q + 1'b1;
        end else if (state_q == ST_LOCK) begin
            code_q   <= best_code;
            done_q   <= 1'b1;
        end
    end

    dcal_settle_timer #(.CNT_W(SETTLE_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .tick_i     (tmr_tick),
        .expired_o  (tmr_expired)
    );

    dcal_peak_track #(.CODE_W(CODE_W), .ENV_W(ENV_W)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (trk_clr),
        .upd_i       (trk_upd),
        .code_i      (code_q),
        .env_i       (env_i),
        .best_code_o (best_code),
        .best_env_o  (best_env)
    );

    assign dco_code_o = code_q;
    assign done_o     = done_q;
    assign peak_o     = best_env;
endmodule

// File: rtl/dco_peak_cal_chk.sv
module dco_peak_cal_chk #(
    parameter int CODE_W = 8,
    parameter int ENV_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              tx_req_i,
    input logic [CODE_W-1:0] dco_code_o,
    input logic              busy_o,
    input logic              done_o,
    input logic [ENV_W-1:0]  peak_o,
    input logic              tx_en_o
);
    assert_tx_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !tx_en_o);

    assert_tx_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (tx_en_o == tx_req_i));

    assert_busy_done_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(dco_code_o) && $stable(peak_o) && $stable(done_o)));

    assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    assert_done_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $fell(busy_o));
endmodule

bind dco_peak_cal dco_peak_cal_chk #(.CODE_W(CODE_W), .ENV_W(ENV_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .tx_req_i   (tx_req_i),
    .dco_code_o (dco_code_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .peak_o     (peak_o),
    .tx_en_o    (tx_en_o)
);

// File: tb/dco_peak_cal_bench.sv
module dco_peak_cal_bench;
    localparam int TOP_ENV = 900;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  code_lo_i = '0;
    logic [7:0]  code_hi_i = '0;
    logic [15:0] settle_i = '0;
    logic [9:0]  env_i;
    logic        tx_req_i = 1'b1;
    logic [7:0]  dco_code_o;
    logic        busy_o, done_o, tx_en_o;
    logic [9:0]  peak_o;

    int centre  = 166;
    int plateau = 0;
    int nvec = 0;
    int nbad = 0;

    always #4 clk = ~clk;

    // Synthetic resonance curve as a function of the applied code
    function automatic int env_of(int code, int c, int p);
        int d, v;
        d = (code > c) ? code - c : c - code;
        if (d <= p) return TOP_ENV;
        v = TOP_ENV - 6 * (d - p);
        return (v < 0) ? 0 : v;
    endfunction

    always_comb env_i = 10'(env_of(int'(dco_code_o), centre, plateau));

    dco_peak_cal u_dco_peak_cal (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .code_lo_i(code_lo_i),
        .code_hi_i(code_hi_i), .settle_i(settle_i), .env_i(env_i), .tx_req_i(tx_req_i),
        .dco_code_o(dco_code_o), .busy_o(busy_o), .done_o(done_o), .peak_o(peak_o),
        .tx_en_o(tx_en_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Runs one calibration and checks its length and result.
    // inject_at > 0 raises start again in that busy cycle (must be ignored).
    task automatic run_cal(input int lo, input int hi, input int settle,
                           input int exp_code, input int exp_peak, input int inject_at);
        int n_codes, exp_busy, cnt;
        n_codes  = (hi < lo) ? 1 : hi - lo + 1;
        exp_busy = n_codes * (settle + 2) + 1;
        @(negedge clk);
        code_lo_i = 8'(lo); code_hi_i = 8'(hi); settle_i = 16'(settle);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R2 busy after start", int'(busy_o), 1);
        chk(done_o == 1'b0, "R2 done cleared", int'(done_o), 0);
        chk(int'(dco_code_o) == lo, "R2/R6 first code", int'(dco_code_o), lo);
        cnt = 0;
        while (busy_o && cnt < 100000) begin
            cnt++;
            if (tx_en_o) chk(1'b0, "R8 tx_en while busy", 1, 0);
            if (inject_at > 0) start_i = (cnt == inject_at || cnt == exp_busy);
            else start_i = 1'b0;
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(cnt == exp_busy, "R3 busy length", cnt, exp_busy);
        chk(done_o == 1'b1, "R3 done at end", int'(done_o), 1);
        chk(int'(dco_code_o) == exp_code, "R4/R5 chosen code", int'(dco_code_o), exp_code);
        chk(int'(peak_o) == exp_peak, "R4 peak value", int'(peak_o), exp_peak);
        chk(tx_en_o == tx_req_i, "R8 tx_en follows request", int'(tx_en_o), int'(tx_req_i));
        @(negedge clk);
        chk(busy_o == 1'b0, "R9 no restart after late start", int'(busy_o), 0);
    endtask

    task automatic t_reset;
        chk(int'(dco_code_o) == 8'h80, "R1 reset code", int'(dco_code_o), 128);
        chk(busy_o == 1'b0, "R1 busy", int'(busy_o), 0);
        chk(done_o == 1'b0, "R1 done", int'(done_o), 0);
        chk(peak_o == 10'd0, "R1 peak", int'(peak_o), 0);
        tx_req_i = 1'b0;
        #1;
        chk(tx_en_o == 1'b0, "R1 tx_en", int'(tx_en_o), 0);
        tx_req_i = 1'b1;
        #1;
        chk(tx_en_o == 1'b1, "R8 tx_en idle", int'(tx_en_o), 1);
    endtask

    task automatic t_full_sweep_high;   // R4 R6: resonance above nominal
        centre = 166; plateau = 0;
        run_cal(0, 255, 2, 166, TOP_ENV, 0);
    endtask

    task automatic t_sweep_low;          // R4: resonance below nominal, zero settle
        centre = 100; plateau = 0;
        run_cal(64, 192, 0, 100, TOP_ENV, 0);
    endtask

    task automatic t_edge_of_window;     // R4 R6: peak outside window, edge code wins
        centre = 166; plateau = 0;
        run_cal(16, 48, 3, 48, env_of(48, 166, 0), 0);
    endtask

    task automatic t_tie;                // R5: flat top over 0x50..0x54
        centre = 82; plateau = 2;
        run_cal(70, 100, 1, 80, TOP_ENV, 0);
    endtask

    task automatic t_reversed;           // R6: end below start measures start only
        centre = 166; plateau = 0;
        run_cal(144, 32, 5, 144, env_of(144, 166, 0), 0);
    endtask

    task automatic t_ignore_start;       // R9: start mid-sweep and in lock cycle
        centre = 120; plateau = 0;
        run_cal(110, 130, 2, 120, TOP_ENV, 4);
    endtask

    task automatic t_frozen;             // R7: curve moves, code stays
        int held;
        held = int'(dco_code_o);
        centre = 30; plateau = 5;
        repeat (20) @(negedge clk);
        chk(int'(dco_code_o) == held, "R7 code frozen", int'(dco_code_o), held);
        chk(done_o == 1'b1, "R7 done held", int'(done_o), 1);
        chk(int'(peak_o) == TOP_ENV, "R7 peak held", int'(peak_o), TOP_ENV);
    endtask

    initial begin
        #100000000;
        nbad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_full_sweep_high();
        t_sweep_low();
        t_edge_of_window();
        t_tie();
        t_reversed();
        t_ignore_start();
        t_frozen();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule